// File: doc/BRIEF.md
# External Trigger Clock Conditioner

This block turns an asynchronous external trigger pin into a clean count source for a timer counter running on the timer clock. The pin is first brought into the timer clock domain through a synchroniser chain. A polarity select then picks which level, and so which edge, counts as active. A two-state edge detector turns each inactive-to-active transition into a one-cycle pulse. A power-of-two prescaler passes one pulse in every 1, 2, 4 or 8 edges, and each surviving pulse advances an up-counter by exactly one.

A small configuration register holds the polarity, the dedicated external-clock enable, the prescaler ratio, a slave-mode code and a trigger-source code. The counter runs from the conditioned trigger if the dedicated enable is set, or if the slave mode selects external clocking with the trigger source pointing at the external trigger. When both routes are set, the source is still the conditioned trigger. The conditioned trigger level is exported so that a slave-mode controller can use it for reset, gated or trigger operation. A flag reports the one combination that is not allowed: the dedicated enable used together with one of those three slave modes while the trigger source also names the external trigger. The external pin must toggle no faster than one active edge per four timer clocks after the prescaler.

The edge detector has two states. `ST_IDLE` means the conditioned level is inactive. On an active level it takes the `ST_IDLE -> ST_ACTIVE` transition and emits one edge pulse in that cycle. `ST_ACTIVE` holds while the level stays active, and it takes the `ST_ACTIVE -> ST_IDLE` transition when the level returns to inactive. That transition produces no pulse.

Top module: `ext_trig_cond`

## Requirements
- R1: After reset the configuration reads back as zero (non-inverted, prescaler off, dedicated enable off), the count is zero, and `cnt_en_o` and `cfg_illegal_o` are low.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the configuration, and `cfg_q` shows it from the next cycle. Field layout: bit 0 is the invert flag, bit 1 is the dedicated external-clock enable, bits 3:2 are the prescaler code, bits 6:4 are the slave-mode code, and bits 9:7 are the trigger-source code.
- R3: `trig_level_o` equals the synchronised pin XOR the invert flag. A pin change driven before clock edge k shows on `trig_level_o` after edge k+1 and not after edge k. Invert 0 makes high active and invert 1 makes low active.
- R4: An inactive-to-active change of the conditioned level gives a pulse on `cnt_en_o` (ratio 1, counting enabled) in the cycle after edge k+1. The pulse lasts exactly one cycle even when the level stays active.
- R5: The prescaler code selects one count per 2^code active edges: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R6: With the dedicated enable at 1, every prescaled active edge advances `count_o` by one.
- R7: With the dedicated enable at 0, slave mode 7 and trigger source 7 count exactly like the dedicated enable. With both routes set, the count still follows the conditioned trigger.
- R8: With the dedicated enable at 0 and not both slave mode 7 and trigger source 7, `cnt_en_o` stays low and `count_o` does not move, while `trig_level_o` still follows the pin.
- R9: `cfg_illegal_o` is high exactly when the dedicated enable is 1, the slave mode is 4, 5 or 6 (reset, gated, trigger) and the trigger source is 7.
- R10: Every configuration write restarts the prescaler, so the edge count toward the next pulse begins again at zero.
- R11: `count_o` changes only by +1 on a cycle after `cnt_en_o` is high and wraps from all ones to zero. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration write data |
| cfg_q | output | 10 | Current configuration |
| trig_level_o | output | 1 | Synchronised, polarity-corrected trigger level |
| cnt_en_o | output | 1 | One-cycle count enable after prescaling |
| count_o | output | CNT_W | Up-counter value |
| cfg_illegal_o | output | 1 | Forbidden mode combination flag |

## Verification
The hardest condition to reach from the ports is the prescaler's partial progress, because no output shows how many edges it has already absorbed. The bench sends a known number of edges that is smaller than the ratio. It then rewrites the configuration and sends a further short burst. The result shows whether the earlier edges were discarded. Before each configuration write, the bench also parks the pin at the new inactive level. This keeps a polarity change from creating a false edge, so the count deltas in the sweep over polarity, ratio and source can be predicted exactly.

// File: rtl/etc_pkg.sv
package etc_pkg;
    localparam int DIV_W = 2;

    typedef struct packed {
        logic [2:0]       trig_sel;
        logic [2:0]       slave_mode;
        logic [DIV_W-1:0] div_sel;
        logic             ext2_en;
        logic             invert;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } edge_st_e;

    localparam logic [2:0] SM_RESET = 3'b100;
    localparam logic [2:0] SM_GATED = 3'b101;
    localparam logic [2:0] SM_TRIG  = 3'b110;
    localparam logic [2:0] SM_EXT1  = 3'b111;
    localparam logic [2:0] TS_EXT   = 3'b111;
endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[g] <= 1'b0;
                else if (g == 0)
                    chain[g] <= d_i;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/etc_edge_fsm.sv
module etc_edge_fsm
    import etc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic invert_i,
    output logic level_o,
    output logic edge_o
);
    edge_st_e state, state_nxt;
    logic     active;

    assign active = sync_i ^ invert_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        edge_o    = 1'b0;
        level_o   = active;
        unique case (state)
            ST_IDLE: begin
                if (active) begin
                    state_nxt = ST_ACTIVE;
                    edge_o    = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (!active)
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // R4: an edge pulse never lasts two cycles
    assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/etc_prescale.sv
module etc_prescale
    import etc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             edge_i,
    input  logic [DIV_W-1:0] div_sel_i,
    output logic             pulse_o
);
    localparam int PC_W = (1 << DIV_W) - 1;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] limit;

    assign limit   = (PC_W'(1) << div_sel_i) - PC_W'(1);
    assign pulse_o = edge_i && (pcnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clr_i)
            pcnt <= '0;
        else if (edge_i)
            pcnt <= (pcnt == limit) ? '0 : pcnt + PC_W'(1);
    end

    // R5: the edge counter stays below the selected ratio
    assert_ratio_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= limit || $past(clr_i) || $changed(div_sel_i));
    // R10: a configuration write restarts the prescaler
    assert_clear_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> pcnt == '0);
endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond
    import etc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_trig_i,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_q,
    output logic                 trig_level_o,
    output logic                 cnt_en_o,
    output logic [CNT_W-1:0]     count_o,
    output logic                 cfg_illegal_o
);
    cfg_t cfg;
    logic sync_trig;
    logic edge_pulse;
    logic presc_pulse;
    logic ext_active;
    logic mode1_ext;
    logic slave_conflict;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg <= '0;
        else if (cfg_we)
            cfg <= cfg_t'(cfg_wdata);
    end

    assign cfg_q = cfg;

    etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ext_trig_i),
        .q_o   (sync_trig)
    );

    etc_edge_fsm u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (sync_trig),
        .invert_i (cfg.invert),
        .level_o  (trig_level_o),
        .edge_o   (edge_pulse)
    );

    etc_prescale u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cfg_we),
        .edge_i    (edge_pulse),
        .div_sel_i (cfg.div_sel),
        .pulse_o   (presc_pulse)
    );

    assign mode1_ext  = (cfg.slave_mode == SM_EXT1) && (cfg.trig_sel == TS_EXT);
    assign ext_active = cfg.ext2_en || mode1_ext;

    always_comb begin
        unique case (cfg.slave_mode)
            SM_RESET, SM_GATED, SM_TRIG: slave_conflict = 1'b1;
            default:                     slave_conflict = 1'b0;
        endcase
    end

    assign cfg_illegal_o = cfg.ext2_en && slave_conflict && (cfg.trig_sel == TS_EXT);
    assign cnt_en_o      = presc_pulse && ext_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_o <= '0;
        else if (cnt_en_o)
            count_o <= count_o + CNT_W'(1);
    end

    // R11: count steps by exactly one after an enable pulse
    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_o |=> count_o == $past(count_o) + CNT_W'(1));
    // R11: count holds without an enable pulse
    assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_o |=> $stable(count_o));
    // R8: no enable pulse while no external clock route is selected
    assert_no_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[1] && !(cfg_q[6:4] == 3'b111 && cfg_q[9:7] == 3'b111)) |-> !cnt_en_o);
endmodule

// File: tb/sim_ext_trig_cond.sv
module sim_ext_trig_cond;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_trig_i = 1'b0;
    logic          cfg_we = 1'b0;
    logic [9:0]    cfg_wdata = '0;
    logic [9:0]    cfg_q;
    logic          trig_level_o;
    logic          cnt_en_o;
    logic [CW-1:0] count_o;
    logic          cfg_illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ext_trig_cond #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_trig_i    (ext_trig_i),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .cfg_q         (cfg_q),
        .trig_level_o  (trig_level_o),
        .cnt_en_o      (cnt_en_o),
        .count_o       (count_o),
        .cfg_illegal_o (cfg_illegal_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] pack(input bit inv, input bit e2, input int dv,
                                        input int sm, input int ts);
        return {3'(ts), 3'(sm), 2'(dv), e2, inv};
    endfunction

    task automatic wr(input logic [9:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // park the pin at the new inactive level, then write
    task automatic set_cfg(input bit inv, input bit e2, input int dv, input int sm, input int ts);
        ext_trig_i = inv;
        repeat (4) @(negedge clk);
        wr(pack(inv, e2, dv, sm, ts));
        repeat (3) @(negedge clk);
    endtask

    task automatic pulses(input bit inv, input int n, input bit lvl_chk);
        for (int i = 0; i < n; i++) begin
            ext_trig_i = ~inv;
            repeat (4) @(negedge clk);
            if (lvl_chk && i == 0) chk("R3 level active", trig_level_o, 1);
            ext_trig_i = inv;
            repeat (4) @(negedge clk);
            if (lvl_chk && i == 0) chk("R3 level inactive", trig_level_o, 0);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] base;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cfg", cfg_q, 0);
        chk("R1 count", count_o, 0);
        chk("R1 cnt_en", cnt_en_o, 0);
        chk("R1 illegal", cfg_illegal_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 level", trig_level_o, 0);

        // R2 write and readback
        wr(10'h2A5);
        chk("R2 readback", cfg_q, 10'h2A5);
        wr(10'h000);
        chk("R2 readback zero", cfg_q, 0);

        // R3/R4 latency and pulse width, dedicated enable, ratio 1
        set_cfg(0, 1, 0, 0, 0);
        base = count_o;
        @(negedge clk);
        ext_trig_i = 1'b1;
        @(posedge clk); #1;
        chk("R3 level not yet", trig_level_o, 0);
        chk("R4 no early pulse", cnt_en_o, 0);
        @(posedge clk); #1;
        chk("R3 level after two edges", trig_level_o, 1);
        chk("R4 pulse", cnt_en_o, 1);
        @(posedge clk); #1;
        chk("R4 single cycle", cnt_en_o, 0);
        chk("R11 step", CW'(count_o - base), 1);
        repeat (5) @(posedge clk); #1;
        chk("R4 held level no pulse", CW'(count_o - base), 1);
        ext_trig_i = 1'b0;
        repeat (4) @(negedge clk);

        // sweep: polarity x ratio x source (R3 R5 R6 R7 R8 R11)
        for (int inv = 0; inv < 2; inv++)
            for (int dv = 0; dv < 4; dv++)
                for (int md = 0; md < 4; md++) begin
                    int exp;
                    bit e2;
                    int sm, ts;
                    // md0: dedicated; md1: mode-1 route; md2: both; md3: none
                    e2 = (md == 0 || md == 2);
                    sm = (md == 1 || md == 2) ? 7 : (md == 3 ? 7 : 0);
                    ts = (md == 1 || md == 2) ? 7 : (md == 3 ? 3 : 0);
                    set_cfg(bit'(inv), e2, dv, sm, ts);
                    base = count_o;
                    pulses(bit'(inv), 11, 1'b1);
                    exp = (md == 3) ? 0 : (11 >> dv);
                    case (md)
                        0: chk("R6 dedicated count R5", CW'(count_o - base), exp);
                        1: chk("R7 mode-1 count R5", CW'(count_o - base), exp);
                        2: chk("R7 both routes count", CW'(count_o - base), exp);
                        default: chk("R8 no count", CW'(count_o - base), exp);
                    endcase
                end

        // R10 prescaler restart on write: ratio 4, 3 edges, rewrite, 2 edges -> 0
        set_cfg(0, 1, 2, 0, 0);
        base = count_o;
        pulses(0, 3, 1'b0);
        wr(pack(0, 1, 2, 0, 0));
        pulses(0, 2, 1'b0);
        chk("R10 restart", CW'(count_o - base), 0);
        pulses(0, 2, 1'b0);
        chk("R10 after four", CW'(count_o - base), 1);

        // R11 wrap: ratio 1, run 20 pulses from a known base
        set_cfg(0, 1, 0, 0, 0);
        base = count_o;
        pulses(0, 20, 1'b0);
        chk("R11 wrap", count_o, int'(CW'(base + CW'(20))));

        // R9 illegal combination sweep
        ext_trig_i = 1'b0;
        for (int e2 = 0; e2 < 2; e2++)
            for (int sm = 0; sm < 8; sm++)
                for (int ts = 0; ts < 8; ts++) begin
                    wr(pack(0, bit'(e2), 0, sm, ts));
                    chk("R9 illegal", cfg_illegal_o,
                        int'(e2 == 1 && sm >= 4 && sm <= 6 && ts == 7));
                end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule